// File: doc/BRIEF.md
# Page-Buffered Write Commit Controller

This block sits between a serial slave engine and a byte-wide storage array. The slave engine sends it three kinds of event: an address load, each received data byte, and the start and stop conditions seen on the bus. The block keeps the current address pointer. It gathers data bytes in a page latch that is one physical page wide, and it records which entries of that latch hold a byte from the current transaction.

Incoming bytes land at the pointer's offset inside its page. Only the offset bits advance, so a long burst wraps back to the start of the same page and overwrites bytes taken earlier. When a stop ends a transaction that carried data, the write-protect input is sampled once. If protection is off, the block raises a busy flag for a fixed, parameterised number of clock cycles. During the first part of that window it copies every written latch entry to the array, and untouched offsets of the page keep their old contents. The slave engine uses the busy flag to withhold acknowledges. If protection is on, the bytes are dropped, busy stays low and the block is ready for the next command at once.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, busy and arr_we are low and cur_ptr is zero.
- R2: An accepted addr_load sets cur_ptr to addr_in on the next cycle.
- R3: Each accepted byte_stb stores byte_in at latch offset cur_ptr[4:0] and adds one to those five bits modulo 32. Bits [11:5] of cur_ptr do not change, so the write wraps to the start of the same page.
- R4: When more than 32 bytes arrive before the stop, each later byte replaces the earlier byte at the same offset, and only the latest byte is committed.
- R5: A stop with at least one latched byte and wp_in low raises busy on the next cycle and holds it for exactly BUSY_CYCLES cycles.
- R6: During busy, arr_we pulses once for each latch offset written in the transaction, in ascending offset order. Each write uses arr_addr = {cur_ptr[11:5], offset} and the latest byte for that offset. Offsets that were not written produce no array write.
- R7: A stop with wp_in high produces no array write and no busy cycle, and a transaction that begins on the very next cycle is accepted and committed.
- R8: A change of wp_in after the stop has been sampled does not alter the commit already under way.
- R9: A stop that follows only an address load, with no data bytes, starts no busy period and no array write, and cur_ptr keeps the loaded value.
- R10: While busy is high, start_evt, addr_load and byte_stb are ignored. cur_ptr is left unchanged and no byte is latched, so a stop issued after busy falls starts nothing.
- R11: A start condition discards bytes latched by a transaction that had not yet ended with a stop, so a stop that follows such a start commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_evt | input | 1 | One-cycle strobe: bus start condition |
| stop_evt | input | 1 | One-cycle strobe: bus stop condition |
| addr_load | input | 1 | One-cycle strobe: load pointer from addr_in |
| addr_in | input | ADDR_W (12) | Word address assembled by the slave engine |
| byte_stb | input | 1 | One-cycle strobe: data byte received |
| byte_in | input | DATA_W (8) | Received data byte |
| wp_in | input | 1 | Write-protect level, sampled at stop |
| busy | output | 1 | High for the whole self-timed write interval |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W (12) | Array write address |
| arr_wdata | output | DATA_W (8) | Array write data |
| cur_ptr | output | ADDR_W (12) | Current address pointer |

## Verification
The main commit path is driven with a table of write transactions that differ in start offset, byte count and protect level. The table covers a single byte, a short burst in the middle of a page, a burst that crosses the page end, an exact full page, a 40-byte overrun, a protected burst, an address-only command and a wrap in the topmost page. For each one the bench checks the number of busy cycles, the number, order, page and data of the array writes against offsets it computes itself, and the final pointer. These results separate a true in-page wrap from a spill into the next page, last-wins overwrite from first-wins, and a protected drop from a commit. Directed cases then toggle protect during busy, send strobes while busy and abort a transaction with a repeated start.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
   typedef enum logic {
      PW_IDLE = 1'b0,
      PW_BUSY = 1'b1
   } pw_state_e;
endpackage

// File: rtl/pgw_latch.sv
module pgw_latch #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 32,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              any_valid
);
   logic [DEPTH-1:0]  vld;
   logic [DATA_W-1:0] mem [DEPTH];

   if ((1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("pgw_latch: DEPTH must be a power of two");
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld[e] <= 1'b0;
            mem[e] <= '0;
         end else if (clr) begin
            vld[e] <= 1'b0;
         end else if (wr_en && wr_idx == IDX_W'(e)) begin
            vld[e] <= 1'b1;
            mem[e] <= wr_data;
         end
      end
   end

   assign rd_data   = mem[rd_idx];
   assign rd_valid  = vld[rd_idx];
   assign any_valid = |vld;
endmodule

// File: rtl/pgw_timer.sv
module pgw_timer
   import pgw_pkg::*;
#(
   parameter int CYCLES = 64,
   localparam int CNT_W = $clog2(CYCLES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   output logic             busy,
   output logic             done,
   output logic [CNT_W-1:0] tick
);
   pw_state_e        st;
   logic [CNT_W-1:0] cnt;

   if (CYCLES < 1) begin : g_bad_cycles
      $error("pgw_timer: CYCLES must be at least one");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= PW_IDLE;
         cnt <= '0;
      end else if (st == PW_IDLE) begin
         if (launch) begin
            st  <= PW_BUSY;
            cnt <= '0;
         end
      end else if (cnt == CNT_W'(CYCLES - 1)) begin
         st  <= PW_IDLE;
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign busy = (st == PW_BUSY);
   assign done = busy && (cnt == CNT_W'(CYCLES - 1));
   assign tick = cnt;

   // R5: busy ends only after the full count
   assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(cnt) == CNT_W'(CYCLES - 1));
   // R5: a launch from idle always opens the window
   assert_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && !busy) |=> busy);
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl #(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 8,
   parameter int PAGE_BYTES  = 32,
   parameter int BUSY_CYCLES = 1000,
   localparam int IDX_W  = $clog2(PAGE_BYTES),
   localparam int PAGE_W = ADDR_W - IDX_W,
   localparam int CNT_W  = $clog2(BUSY_CYCLES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic              addr_load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              byte_stb,
   input  logic [DATA_W-1:0] byte_in,
   input  logic              wp_in,
   output logic              busy,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_wdata,
   output logic [ADDR_W-1:0] cur_ptr
);
   if (BUSY_CYCLES < PAGE_BYTES) begin : g_bad_busy
      $error("page_write_ctrl: BUSY_CYCLES must cover one page sweep");
   end
   if (PAGE_W < 1) begin : g_bad_addr
      $error("page_write_ctrl: ADDR_W must exceed the page offset width");
   end

   logic [ADDR_W-1:0] ptr_q;
   logic              accept, launch, clr, done;
   logic              rd_valid, any_valid;
   logic [DATA_W-1:0] rd_data;
   logic [CNT_W-1:0]  tick;
   logic [IDX_W-1:0]  sweep_idx;
   logic              in_sweep;

   assign accept = !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (accept && addr_load) begin
         ptr_q <= addr_in;
      end else if (accept && byte_stb) begin
         ptr_q <= {ptr_q[ADDR_W-1:IDX_W], ptr_q[IDX_W-1:0] + 1'b1};
      end
   end

   assign launch = accept && stop_evt && !wp_in && any_valid;
   assign clr    = (accept && start_evt) || (accept && stop_evt && wp_in) || done;

   assign sweep_idx = tick[IDX_W-1:0];
   assign in_sweep  = busy && (tick < CNT_W'(PAGE_BYTES));

   pgw_latch #(.DATA_W(DATA_W), .DEPTH(PAGE_BYTES)) u_latch (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .wr_en(accept && byte_stb), .wr_idx(ptr_q[IDX_W-1:0]), .wr_data(byte_in),
      .rd_idx(sweep_idx), .rd_data(rd_data), .rd_valid(rd_valid),
      .any_valid(any_valid)
   );

   pgw_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .launch(launch),
      .busy(busy), .done(done), .tick(tick)
   );

   assign arr_we    = in_sweep && rd_valid;
   assign arr_addr  = {ptr_q[ADDR_W-1:IDX_W], sweep_idx};
   assign arr_wdata = rd_data;
   assign cur_ptr   = ptr_q;

   // R6: array writes only inside the busy window
   assert_we_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> busy);
   // R7: protected stop never opens a busy window
   assert_wp_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_evt && wp_in && !busy) |=> !busy);
   // R3: a data byte never moves the page bits
   assert_page_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_stb && !addr_load && !busy) |=>
         cur_ptr[ADDR_W-1:IDX_W] == $past(cur_ptr[ADDR_W-1:IDX_W]));
   // R10: pointer frozen while busy
   assert_busy_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cur_ptr));
   // R9: stop with an empty latch starts nothing
   assert_empty_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_evt && !busy && !any_valid) |=> !busy);
endmodule

// File: tb/page_write_ctrl_test.sv
`timescale 1ns/1ps
module page_write_ctrl_test;
   localparam int BUSY = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_evt = 0, stop_evt = 0, addr_load = 0, byte_stb = 0, wp_in = 0;
   logic [11:0] addr_in = '0;
   logic [7:0]  byte_in = '0;
   logic        busy, arr_we;
   logic [11:0] arr_addr, cur_ptr;
   logic [7:0]  arr_wdata;

   page_write_ctrl #(.ADDR_W(12), .DATA_W(8), .PAGE_BYTES(32), .BUSY_CYCLES(BUSY)) uut (
      .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
      .addr_load(addr_load), .addr_in(addr_in), .byte_stb(byte_stb), .byte_in(byte_in),
      .wp_in(wp_in), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
      .arr_wdata(arr_wdata), .cur_ptr(cur_ptr)
   );

   always #2.5 clk = ~clk;

   int checks = 0, fails = 0;
   bit finished = 0;

   // monitor state
   int        busy_cnt, wr_cnt;
   bit        order_bad, page_bad, have_last;
   logic [11:0] last_addr;
   logic [6:0]  exp_page;
   bit        seen [32];
   logic [7:0] got [32];

   // table: {addr[11:0], count[6:0], wp}
   localparam logic [19:0] VEC [8] = '{
      {12'h100, 7'd1,  1'b0},
      {12'h235, 7'd4,  1'b0},
      {12'h31C, 7'd8,  1'b0},
      {12'h400, 7'd32, 1'b0},
      {12'h4A3, 7'd40, 1'b0},
      {12'h500, 7'd5,  1'b1},
      {12'h600, 7'd0,  1'b0},
      {12'hFFE, 7'd3,  1'b0}
   };

   always @(negedge clk) begin
      if (busy) busy_cnt++;
      if (arr_we) begin
         wr_cnt++;
         if (have_last && arr_addr <= last_addr) order_bad = 1;
         if (arr_addr[11:5] != exp_page) page_bad = 1;
         have_last = 1;
         last_addr = arr_addr;
         seen[arr_addr[4:0]] = 1;
         got[arr_addr[4:0]]  = arr_wdata;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_mon(input logic [6:0] pg);
      @(posedge clk); #1;
      busy_cnt = 0; wr_cnt = 0; order_bad = 0; page_bad = 0; have_last = 0;
      exp_page = pg;
      for (int k = 0; k < 32; k++) begin seen[k] = 0; got[k] = '0; end
   endtask

   task automatic p_start();
      @(negedge clk); start_evt = 1; @(posedge clk); #1 start_evt = 0;
   endtask
   task automatic p_stop();
      @(negedge clk); stop_evt = 1; @(posedge clk); #1 stop_evt = 0;
   endtask
   task automatic p_addr(input logic [11:0] a);
      @(negedge clk); addr_load = 1; addr_in = a; @(posedge clk); #1 addr_load = 0;
   endtask
   task automatic p_byte(input logic [7:0] d);
      @(negedge clk); byte_stb = 1; byte_in = d; @(posedge clk); #1 byte_stb = 0;
   endtask
   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog (R1..all) actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk("R1 busy", busy, 0);
      chk("R1 arr_we", arr_we, 0);
      chk("R1 cur_ptr", cur_ptr, 0);
      rst_n = 1;
      idle(2);

      // table-driven transactions (R2 R3 R4 R5 R6 R7 R9)
      for (int v = 0; v < 8; v++) begin
         logic [11:0] a;
         int n;
         logic wp;
         bit ev [32];
         logic [7:0] ed [32];
         int ecount, mism;
         a = VEC[v][19:8]; n = int'(VEC[v][7:1]); wp = VEC[v][0];
         for (int k = 0; k < 32; k++) begin ev[k] = 0; ed[k] = '0; end
         clear_mon(a[11:5]);
         p_start();
         p_addr(a);
         for (int j = 0; j < n; j++) begin
            logic [7:0] d;
            int o;
            d = 8'(v * 37 + j * 11 + 5);
            o = (int'(a[4:0]) + j) % 32;
            ev[o] = 1; ed[o] = d;
            p_byte(d);
         end
         wp_in = wp;
         p_stop();
         #1 wp_in = 0;
         idle(BUSY + 4);
         ecount = 0;
         for (int k = 0; k < 32; k++) if (ev[k]) ecount++;
         if (wp) ecount = 0;
         mism = 0;
         for (int k = 0; k < 32; k++)
            if (seen[k] != (ev[k] && !wp) || (seen[k] && got[k] != ed[k])) mism++;
         chk("R2/R3 final pointer", cur_ptr, {a[11:5], 5'(int'(a[4:0]) + n)});
         chk("R5/R7/R9 busy cycles", busy_cnt, (n > 0 && !wp) ? BUSY : 0);
         chk("R6/R7/R9 write count", wr_cnt, ecount);
         chk("R4/R6 offset data mismatches", mism, 0);
         chk("R6 ascending order", order_bad, 0);
         chk("R3/R6 page bits", page_bad, 0);
      end

      // R7: protected stop then an immediate new transaction
      clear_mon(7'h48);
      p_start(); p_addr(12'h910); p_byte(8'h11);
      wp_in = 1; p_stop(); wp_in = 0;
      chk("R7 not busy after protected stop", busy, 0);
      p_start(); p_addr(12'h905); p_byte(8'h22); p_stop();
      idle(BUSY + 4);
      chk("R7 next command writes", wr_cnt, 1);
      chk("R7 next command data", got[5], 8'h22);
      chk("R7 protected byte dropped", seen[16], 0);

      // R8: protect raised during the commit
      clear_mon(7'h38);
      p_start(); p_addr(12'h700); p_byte(8'hA1); p_byte(8'hA2);
      p_stop();
      wp_in = 1;
      // R10: strobes while busy are ignored
      p_start(); p_addr(12'h0AA); p_byte(8'hEE);
      idle(BUSY + 4);
      wp_in = 0;
      chk("R8 writes despite late protect", wr_cnt, 2);
      chk("R8 busy cycles", busy_cnt, BUSY);
      chk("R10 pointer unchanged by busy strobes", cur_ptr, 12'h702);
      clear_mon(7'h38);
      p_stop();
      idle(BUSY + 4);
      chk("R10 busy-time byte not latched", busy_cnt, 0);
      chk("R10 no write after stray stop", wr_cnt, 0);

      // R11: repeated start discards uncommitted bytes
      clear_mon(7'h40);
      p_start(); p_addr(12'h800); p_byte(8'h01); p_byte(8'h02); p_byte(8'h03);
      p_start(); p_stop();
      idle(BUSY + 4);
      chk("R11 no busy after aborted write", busy_cnt, 0);
      chk("R11 no write after aborted write", wr_cnt, 0);
      chk("R11 pointer advanced", cur_ptr, 12'h803);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule